// File: doc/BRIEF.md
# Output Colour Matrix Converter

This block sits at the end of a pixel pipeline. It takes one RGB pixel per clock, with 12 bits per component and a valid flag. It passes each pixel through a 3x4 fixed-point matrix and presents the result three cycles later, with the valid flag delayed to match.

A mode code selects the coefficient set. Four sets are built in: pass-through, limited-range RGB, BT.601 YCbCr and BT.709 YCbCr. A fifth code selects twelve coefficients that software loads through a small write port. All writes land in a shadow copy first. A frame-start strobe moves the shadow copy into use, so one frame is never converted with a mix of old and new settings.

In the YCbCr modes, output row 0 carries Cr, row 1 carries Y and row 2 carries Cb. These appear on the red, green and blue output ports respectively.

Top module: `color_matrix_conv`

## Requirements
- R1: While reset is held and after it is released, out_valid_o is 0, all output components are 0, the active mode is 0 and every programmable coefficient is 0.
- R2: A pixel sampled on a rising edge appears on the outputs after the third rising edge counted from that edge, with out_valid_o equal to the pix_valid_i that came with it.
- R3: Mode 0, and the unassigned mode codes 5, 6 and 7, return every input component unchanged.
- R4: Mode 1 gives each output component x*0x1B60 + 0x200*4096, taken through the arithmetic of R8. There are no cross terms.
- R5: Mode 2 uses these coefficient rows, given as (R gain, G gain, B gain, offset) and listed top to bottom as outputs R, G, B:
  - (0xE00, 0xF447, 0xFDB9, 0x1000)
  - (0x82F, 0x1012, 0x31F, 0x200)
  - (0xFB47, 0xF6B9, 0xE00, 0x1000)
- R6: Mode 3 uses these rows, in the same form:
  - (0xE00, 0xF349, 0xFEB7, 0x1000)
  - (0x5D2, 0x1394, 0x1FA, 0x200)
  - (0xFCCB, 0xF535, 0xE00, 0x1000)
- R7: Mode 4 uses the programmable coefficients. A write to address 4*row+col (col 3 is the offset, row 0..2) stores the 16-bit two's-complement value in the shadow copy. Address 12 stores the mode from bits [2:0]. Writes to addresses 13 to 15 have no effect.
- R8: For each output row, acc = sum(coef*component) + offset*4096, where 0x2000 is a gain of 1.0. The output is (acc + 4096) shifted arithmetically right by 13, then saturated to 0..4095.
- R9: Shadow writes do not change the outputs until a frame_start_i strobe. The pixel sampled in the strobe cycle is still converted with the previous set, and pixels sampled in later cycles use the new set.
- R10: A write in the same cycle as frame_start_i goes only to the shadow copy. It takes effect at the following strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_r_i | input | 12 | Input red component |
| pix_g_i | input | 12 | Input green component |
| pix_b_i | input | 12 | Input blue component |
| frame_start_i | input | 1 | Commits shadow settings to the active set |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_addr_i | input | 4 | Configuration address |
| cfg_wdata_i | input | 16 | Configuration write data |
| out_valid_o | output | 1 | Output pixel valid |
| out_r_o | output | 12 | Output row 0 (R or Cr) |
| out_g_o | output | 12 | Output row 1 (G or Y) |
| out_b_o | output | 12 | Output row 2 (B or Cb) |

## Verification
A configuration write and a frame-start strobe can occur in the same cycle, and the strobe can also coincide with a live pixel. The bench provokes both cases while pixels stream. It issues a strobe that carries a pixel, and a strobe that carries a mode write. A bench model then judges each converted pixel: it commits the shadow set to the active set before it applies the write, and it converts the strobe-cycle pixel with the set that was active before the strobe. Around these collisions, random pixels and coefficients run through every mode, and directed extremes drive both saturation limits.

// File: rtl/cmc_pkg.sv
// Package: shared widths, mode codes and built-in coefficient sets for the
// colour matrix converter. Assumes a 3x4 matrix stored row-major (col 3 = offset).
package cmc_pkg;
    parameter int CW      = 12;            // component width
    parameter int KW      = 16;            // coefficient width
    parameter int FRAC    = 13;            // fractional bits, 1.0 = 2**FRAC
    parameter int NROW    = 3;
    parameter int NCOL    = 4;
    parameter int NCOEF   = NROW * NCOL;
    parameter int MODE_W  = 3;
    parameter int ADDR_W  = 4;
    parameter int LAT     = 3;             // pipeline depth
    parameter int PROD_W  = CW + 1 + KW;
    parameter int ACC_W   = PROD_W + 3;

    parameter logic [MODE_W-1:0] MODE_PASS  = 3'd0;
    parameter logic [MODE_W-1:0] MODE_TVRGB = 3'd1;
    parameter logic [MODE_W-1:0] MODE_Y601  = 3'd2;
    parameter logic [MODE_W-1:0] MODE_Y709  = 3'd3;
    parameter logic [MODE_W-1:0] MODE_PROG  = 3'd4;
    parameter logic [ADDR_W-1:0] ADDR_MODE  = 4'd12;

    typedef logic [NCOEF-1:0][KW-1:0] coef_vec_t;
    typedef logic [NCOL-1:0][KW-1:0]  coef_row_t;
    typedef logic [NROW-1:0][CW-1:0]  pix_vec_t;

    // Returns the hardwired set for a mode; unknown codes give the identity.
    function automatic coef_vec_t builtin_set(input logic [MODE_W-1:0] m);
        coef_vec_t k;
        k = '0;
        case (m)
            MODE_TVRGB: begin
                k[0] = 16'h1B60; k[5] = 16'h1B60; k[10] = 16'h1B60;
                k[3] = 16'h0200; k[7] = 16'h0200; k[11] = 16'h0200;
            end
            MODE_Y601: begin
                k[0] = 16'h0E00; k[1] = 16'hF447; k[2]  = 16'hFDB9; k[3]  = 16'h1000;
                k[4] = 16'h082F; k[5] = 16'h1012; k[6]  = 16'h031F; k[7]  = 16'h0200;
                k[8] = 16'hFB47; k[9] = 16'hF6B9; k[10] = 16'h0E00; k[11] = 16'h1000;
            end
            MODE_Y709: begin
                k[0] = 16'h0E00; k[1] = 16'hF349; k[2]  = 16'hFEB7; k[3]  = 16'h1000;
                k[4] = 16'h05D2; k[5] = 16'h1394; k[6]  = 16'h01FA; k[7]  = 16'h0200;
                k[8] = 16'hFCCB; k[9] = 16'hF535; k[10] = 16'h0E00; k[11] = 16'h1000;
            end
            default: begin
                k[0] = 16'h2000; k[5] = 16'h2000; k[10] = 16'h2000;
            end
        endcase
        return k;
    endfunction
endpackage

// File: rtl/cmc_coef_bank.sv
// Coefficient bank: a shadow copy written by the config port, and an active copy
// loaded from the shadow only on frame_start_i. It presents the coefficients that
// the active mode selects. Assumes the strobe comes before a frame's first pixel.
module cmc_coef_bank
    import cmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [KW-1:0]     cfg_wdata_i,
    output coef_vec_t         coef_o
);
    coef_vec_t         shadow_coef, act_coef;
    logic [MODE_W-1:0] shadow_mode, act_mode;

    // Capture software writes into the shadow copy; unmapped addresses are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_coef <= '0;
            shadow_mode <= MODE_PASS;
        end else if (cfg_we_i) begin
            if (cfg_addr_i < ADDR_W'(NCOEF))
                shadow_coef[cfg_addr_i] <= cfg_wdata_i;
            else if (cfg_addr_i == ADDR_MODE)
                shadow_mode <= cfg_wdata_i[MODE_W-1:0];
        end
    end

    // Commit the shadow copy on the frame strobe (pre-write shadow value).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_coef <= '0;
            act_mode <= MODE_PASS;
        end else if (frame_start_i) begin
            act_coef <= shadow_coef;
            act_mode <= shadow_mode;
        end
    end

    // Choose programmable or hardwired coefficients by the active mode.
    always_comb begin
        if (act_mode == MODE_PROG) coef_o = act_coef;
        else                       coef_o = builtin_set(act_mode);
    end

    AST_ACTIVE_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(act_coef)); // R9
    AST_ACTIVE_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start_i |=> $stable(act_mode)); // R10
endmodule

// File: rtl/cmc_row.sv
// One matrix row: three products, then sum plus offset, then round and saturate.
// Three register stages, no enables. Assumes unsigned components and signed coefficients.
module cmc_row
    import cmc_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  pix_vec_t      pix_i,
    input  coef_row_t     coef_i,
    output logic [CW-1:0] out_o
);
    localparam int MAXV = (1 << CW) - 1;
    localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC - 1);
    localparam logic signed [ACC_W-1:0] HIGH = ACC_W'(MAXV) <<< FRAC;

    logic signed [PROD_W-1:0] prod_q [NROW];
    logic signed [KW-1:0]     off_q;
    logic signed [ACC_W-1:0]  sum_c, acc_q, shf_c;

    // Stage 1: multiply each component by its gain, keep the offset alongside.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NROW; c++) prod_q[c] <= '0;
            off_q <= '0;
        end else begin
            for (int c = 0; c < NROW; c++)
                prod_q[c] <= $signed({1'b0, pix_i[c]}) * $signed(coef_i[c]);
            off_q <= $signed(coef_i[NCOL-1]);
        end
    end

    // Sum the products and the offset scaled to half an output LSB.
    always_comb begin
        sum_c = ACC_W'(off_q) <<< (FRAC - 1);
        for (int c = 0; c < NROW; c++) sum_c = sum_c + ACC_W'(prod_q[c]);
    end

    // Stage 2: register the accumulated row value.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= sum_c;
    end

    // Round to nearest by adding half, then drop the fractional bits.
    always_comb shf_c = (acc_q + RND) >>> FRAC;

    // Stage 3: saturate to the component range.
    always_ff @(posedge clk) begin
        if (!rst_n)                  out_o <= '0;
        else if (shf_c < 0)          out_o <= '0;
        else if (shf_c > ACC_W'(MAXV)) out_o <= CW'(MAXV);
        else                         out_o <= shf_c[CW-1:0];
    end

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q < 0) |=> (out_o == '0)); // R8
    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q >= HIGH) |=> (out_o == CW'(MAXV))); // R8
endmodule

// File: rtl/color_matrix_conv.sv
// Top: colour matrix converter. One pixel per cycle in, converted pixel LAT cycles
// later. Instantiates the coefficient bank and one row pipeline per output component.
module color_matrix_conv
    import cmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid_i,
    input  logic [CW-1:0]     pix_r_i,
    input  logic [CW-1:0]     pix_g_i,
    input  logic [CW-1:0]     pix_b_i,
    input  logic              frame_start_i,
    input  logic              cfg_we_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [KW-1:0]     cfg_wdata_i,
    output logic              out_valid_o,
    output logic [CW-1:0]     out_r_o,
    output logic [CW-1:0]     out_g_o,
    output logic [CW-1:0]     out_b_o
);
    coef_vec_t           coef_w;
    pix_vec_t            pix_w;
    logic [NROW-1:0][CW-1:0] res_w;
    logic [LAT-1:0]      vld_q;

    assign pix_w = {pix_b_i, pix_g_i, pix_r_i};

    cmc_coef_bank u_bank (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .cfg_we_i      (cfg_we_i),
        .cfg_addr_i    (cfg_addr_i),
        .cfg_wdata_i   (cfg_wdata_i),
        .coef_o        (coef_w)
    );

    for (genvar r = 0; r < NROW; r++) begin : g_row
        cmc_row u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .pix_i  (pix_w),
            .coef_i (coef_w[r*NCOL +: NCOL]),
            .out_o  (res_w[r])
        );
    end

    // Delay the valid flag through as many stages as the data path.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[LAT-2:0], pix_valid_i};
    end

    assign out_valid_o = vld_q[LAT-1];
    assign out_r_o     = res_w[0];
    assign out_g_o     = res_w[1];
    assign out_b_o     = res_w[2];

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(pix_valid_i, 3)); // R2
endmodule

// File: tb/color_matrix_conv_test.sv
`timescale 1ns/1ps
module color_matrix_conv_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic [11:0] pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
    logic        frame_start_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [3:0]  cfg_addr_i = '0;
    logic [15:0] cfg_wdata_i = '0;
    logic        out_valid_o;
    logic [11:0] out_r_o, out_g_o, out_b_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string ph = "R1";

    // bench model of the settings
    logic signed [15:0] sh_k [12], act_k [12];
    int sh_mode = 0, act_mode = 0;

    // expected-output pipe, index 2 is oldest
    bit    ev [3];
    int    er [3], eg [3], eb [3];
    string et [3];

    always #2 clk = ~clk;

    color_matrix_conv uut (.*);

    function automatic int kval(int mode, int idx);
        int t [12];
        for (int i = 0; i < 12; i++) t[i] = 0;
        case (mode)
            1: begin t[0]=32'h1B60; t[5]=32'h1B60; t[10]=32'h1B60; t[3]=32'h200; t[7]=32'h200; t[11]=32'h200; end
            2: t = '{32'hE00,-32'h0BB9,-32'h0247,32'h1000, 32'h82F,32'h1012,32'h31F,32'h200, -32'h04B9,-32'h0947,32'hE00,32'h1000};
            3: t = '{32'hE00,-32'h0CB7,-32'h0149,32'h1000, 32'h5D2,32'h1394,32'h1FA,32'h200, -32'h0335,-32'h0ACB,32'hE00,32'h1000};
            4: return int'(act_k[idx]);
            default: begin t[0]=32'h2000; t[5]=32'h2000; t[10]=32'h2000; end
        endcase
        return t[idx];
    endfunction

    function automatic int calc(int mode, int row, int r, int g, int b);
        longint acc, res;
        acc = longint'(kval(mode,row*4))*r + longint'(kval(mode,row*4+1))*g
            + longint'(kval(mode,row*4+2))*b + longint'(kval(mode,row*4+3))*4096;
        res = (acc + 4096) >>> 13;
        if (res < 0) res = 0;
        if (res > 4095) res = 4095;
        return int'(res);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: check what is due now, then drive the next inputs and update the model.
    task automatic step(bit v, int r, int g, int b, bit fs, bit we, int addr, int data);
        @(negedge clk);
        chk({et[2], " valid"}, int'(out_valid_o), int'(ev[2]));
        if (ev[2]) begin
            chk({et[2], " row0"}, int'(out_r_o), er[2]);
            chk({et[2], " row1"}, int'(out_g_o), eg[2]);
            chk({et[2], " row2"}, int'(out_b_o), eb[2]);
        end
        for (int i = 2; i > 0; i--) begin
            ev[i] = ev[i-1]; er[i] = er[i-1]; eg[i] = eg[i-1]; eb[i] = eb[i-1]; et[i] = et[i-1];
        end
        ev[0] = v; et[0] = ph;
        er[0] = calc(act_mode, 0, r, g, b);
        eg[0] = calc(act_mode, 1, r, g, b);
        eb[0] = calc(act_mode, 2, r, g, b);
        pix_valid_i = v; pix_r_i = 12'(r); pix_g_i = 12'(g); pix_b_i = 12'(b);
        frame_start_i = fs; cfg_we_i = we; cfg_addr_i = 4'(addr); cfg_wdata_i = 16'(data);
        if (fs) begin act_k = sh_k; act_mode = sh_mode; end
        if (we) begin
            if (addr < 12) sh_k[addr] = 16'(data);
            else if (addr == 12) sh_mode = data & 7;
        end
    endtask

    task automatic pix(int r, int g, int b);
        step(1, r, g, b, 0, 0, 0, 0);
    endtask

    task automatic rnd_pix(int n);
        for (int i = 0; i < n; i++)
            step(($urandom_range(0,3) != 0), $urandom_range(0,4095), $urandom_range(0,4095),
                 $urandom_range(0,4095), 0, 0, 0, 0);
    endtask

    task automatic wr(int addr, int data);
        step(0, 0, 0, 0, 0, 1, addr, data);
    endtask

    task automatic strobe();
        step(0, 0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic corners();
        pix(0, 0, 0); pix(4095, 4095, 4095); pix(4095, 0, 0);
        pix(0, 4095, 0); pix(0, 0, 4095); pix(2048, 2048, 2048);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 12; i++) begin sh_k[i] = '0; act_k[i] = '0; end
        for (int i = 0; i < 3; i++) begin ev[i] = 0; er[i] = 0; eg[i] = 0; eb[i] = 0; et[i] = "R2"; end
        repeat (4) @(negedge clk);
        // R1: reset values
        chk("R1 valid", int'(out_valid_o), 0);
        chk("R1 row0", int'(out_r_o), 0);
        chk("R1 row1", int'(out_g_o), 0);
        chk("R1 row2", int'(out_b_o), 0);
        rst_n = 1'b1;
        ph = "R1"; pix(100, 200, 300);       // mode 0 straight after reset
        ph = "R2"; rnd_pix(12);
        ph = "R3"; corners(); rnd_pix(30);
        // R9: shadow write without strobe has no effect
        wr(12, 1);
        ph = "R9"; rnd_pix(10);
        step(1, 1000, 2000, 3000, 1, 0, 0, 0); // strobe pixel: old set
        ph = "R4"; corners(); rnd_pix(30);
        // R10: write coinciding with the strobe stays in shadow
        step(1, 4095, 10, 20, 1, 1, 12, 2);
        ph = "R10"; rnd_pix(10);
        strobe();
        ph = "R5"; corners(); rnd_pix(30);
        wr(12, 3); strobe();
        ph = "R6"; corners(); rnd_pix(30);
        // R7: programmable set, random coefficients
        for (int a = 0; a < 12; a++) wr(a, $urandom_range(0, 65535));
        wr(12, 4); strobe();
        ph = "R7"; rnd_pix(40);
        wr(13, 16'h0001); wr(14, 16'h7FFF); wr(15, 16'h0003); strobe();
        ph = "R7"; rnd_pix(20);
        // R8: saturation both ways and rounding at the half point
        wr(0, 16'h7FFF); wr(1, 16'h7FFF); wr(2, 16'h7FFF); wr(3, 16'h7FFF);
        wr(4, 16'h8000); wr(5, 16'h8000); wr(6, 16'h8000); wr(7, 16'h8000);
        wr(8, 16'h1000); wr(9, 16'h0000); wr(10, 16'h0000); wr(11, 16'h0000);
        strobe();
        ph = "R8"; corners(); pix(1, 0, 0); pix(3, 0, 0); pix(5, 0, 0); rnd_pix(20);
        wr(12, 5); strobe();
        ph = "R3"; corners(); rnd_pix(10);
        wr(12, 7); strobe();
        ph = "R3"; rnd_pix(10);
        ph = "R2"; for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule